// File: doc/BRIEF.md
# TDM Codec Channel Port

This block is the serial side of a single-channel PCM codec that sits on a 2.048 MHz time-division bus with 256 bit periods per 125 µs frame. An active-low sync pulse, sampled on each rising bit-clock edge, aligns a free-running bit counter. The eight bit periods that follow the sync edge form the channel slot. In that slot the block drives the outgoing PCM word onto an output that has an enable (the enable models the three-state buffer). It also collects the incoming PCM word and a serial control word.

A two-bit code gives the three-level address input. It decides at each sync edge whether the slot is used at all and which of two 8-bit control registers receives the serial control word. When the address is low, the control input acts as a static level instead: a low level clears both control registers, and a high level leaves them alone. Register A carries a 3-bit transmit gain code (0 to +7 dB) and a 3-bit receive gain code (0 to −7 dB), both in 1 dB steps. If no further sync arrives, the frame repeats every 256 bits using the slot mode latched at the last sync.

Top module: `tdm_codec_port`

## Requirements
- R1: While reset is asserted, pcm_oe, pcm_out, rx_strobe, rx_pcm, ctl_a, ctl_b, tx_gain and rx_gain are all zero.
- R2: A rising bit-clock edge that samples fsync_n low starts a frame. The eight bit periods right after that edge are the slot, and pcm_oe is low from the ninth period on.
- R3: In the slot, pcm_oe is high and pcm_out carries the tx_pcm value sampled at the sync edge, bit 7 first. Whenever pcm_oe is low, pcm_out is 0.
- R4: pcm_in is sampled at the rising edge that ends each slot bit, first bit into bit 7. The complete word appears on rx_pcm after the eighth bit, and rx_strobe is high for that one period.
- R5: slot_addr sampled at the sync edge selects the mode: 2'b01 uses the slot and loads the control word into ctl_a, 2'b10 uses the slot and loads it into ctl_b, and 2'b00 or 2'b11 leave the slot unused, with no pcm_oe, no rx_pcm update and no control load.
- R6: A control register changes only at the edge that ends the eighth control bit (or through R8). It never shows a partial word.
- R7: A sync sampled during the slot restarts the frame. The partial PCM and control words are discarded and no register is written by them.
- R8: With slot_addr low (00 or 11) at a sync edge, ctl_sin low at that edge clears ctl_a and ctl_b, and ctl_sin high leaves both unchanged.
- R9: tx_gain equals ctl_a[2:0] and rx_gain equals ctl_a[5:3].
- R10: With no further sync, a new slot begins every 256 bit periods in the latched mode. tx_pcm is resampled at the edge that starts it, and PCM and control words are exchanged as in R3 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_n | input | 1 | Active-low frame/channel sync |
| slot_addr | input | 2 | Three-level address code (00 low, 01 mid, 10 high) |
| ctl_sin | input | 1 | Serial control word or static control level |
| pcm_in | input | 1 | Incoming PCM serial data |
| tx_pcm | input | 8 | Outgoing PCM word from the encoder |
| pcm_out | output | 1 | Outgoing PCM serial data |
| pcm_oe | output | 1 | Output enable of the PCM data driver |
| rx_pcm | output | 8 | Last complete incoming PCM word |
| rx_strobe | output | 1 | One-period pulse when rx_pcm is updated |
| ctl_a | output | 8 | Control register A |
| ctl_b | output | 8 | Control register B |
| tx_gain | output | 3 | Transmit gain code |
| rx_gain | output | 3 | Receive gain code |

## Verification
Two situations are the hardest to reach from the ports. The first is the flywheel frame: the bench holds sync inactive for the 248 periods after a slot and then checks that a second slot opens with a freshly sampled transmit word and loads register A. The second is a sync landing in the middle of a slot. The bench asserts it after only four bits with a new address, so the aborted word must leave register A unchanged while the following full slot writes register B. Register clearing is reached by first filling both registers through the address sweep and then issuing a low-address sync with each static level.

// File: rtl/tdm_codec_port_pkg.sv
package tdm_codec_port_pkg;

   typedef enum logic [1:0] {
      SLOT_OFF = 2'd0,
      SLOT_A   = 2'd1,
      SLOT_B   = 2'd2
   } slot_mode_e;

   function automatic slot_mode_e decode_addr(input logic [1:0] lvl);
      case (lvl)
         2'b01:   return SLOT_A;
         2'b10:   return SLOT_B;
         default: return SLOT_OFF;
      endcase
   endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
   import tdm_codec_port_pkg::*;
#(
   parameter int WORD_BITS  = 8,
   parameter int FRAME_BITS = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_n,
   input  logic [1:0] addr,
   input  logic       ctl_lvl,
   output slot_mode_e mode_o,
   output logic       slot_o,
   output logic       last_o,
   output logic       reload_o,
   output logic       clr_o
);
   localparam int CNT_W = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] SLOT_END  = CNT_W'(WORD_BITS - 1);
   localparam logic [CNT_W-1:0] SLOT_SIZE = CNT_W'(WORD_BITS);

   logic [CNT_W-1:0] cnt;
   slot_mode_e       mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         mode <= SLOT_OFF;
      end else if (!sync_n) begin
         cnt  <= '0;
         mode <= decode_addr(addr);
      end else if (cnt == LAST_CNT) begin
         cnt  <= '0;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

   always_comb begin
      mode_o   = mode;
      slot_o   = (mode != SLOT_OFF) && (cnt < SLOT_SIZE);
      last_o   = slot_o && (cnt == SLOT_END) && sync_n;
      reload_o = !sync_n || (cnt == LAST_CNT);
      clr_o    = !sync_n && (decode_addr(addr) == SLOT_OFF) && !ctl_lvl;
   end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] word,
   output logic         sout
);
   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= word;
      else if (shift) sh <= {sh[W-2:0], 1'b0};
   end

   assign sout = shift & sh[W-1];

endmodule

// File: rtl/tdm_deser.sv
module tdm_deser #(
   parameter int W    = 8,
   parameter bit HOLD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         commit,
   input  logic         sin,
   output logic [W-1:0] word_o,
   output logic         valid_o
);
   logic [W-2:0] sh;
   logic [W-1:0] next_word;

   assign next_word = {sh, sin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (shift) sh <= next_word[W-2:0];
   end

   generate
      if (HOLD) begin : g_held
         logic [W-1:0] word_q;
         logic         valid_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q  <= '0;
               valid_q <= 1'b0;
            end else begin
               valid_q <= commit;
               if (commit) word_q <= next_word;
            end
         end
         assign word_o  = word_q;
         assign valid_o = valid_q;
      end else begin : g_direct
         assign word_o  = next_word;
         assign valid_o = commit;
      end
   endgenerate

endmodule

// File: rtl/tdm_ctl_bank.sv
module tdm_ctl_bank #(
   parameter int W         = 8,
   parameter int GAIN_BITS = 3,
   parameter int TXG_LSB   = 0,
   parameter int RXG_LSB   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 a_load,
   input  logic                 b_load,
   input  logic                 clr,
   input  logic [W-1:0]         word,
   output logic [W-1:0]         reg_a,
   output logic [W-1:0]         reg_b,
   output logic [GAIN_BITS-1:0] tx_gain,
   output logic [GAIN_BITS-1:0] rx_gain
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a <= '0;
         reg_b <= '0;
      end else if (clr) begin
         reg_a <= '0;
         reg_b <= '0;
      end else begin
         if (a_load) reg_a <= word;
         if (b_load) reg_b <= word;
      end
   end

   assign tx_gain = reg_a[TXG_LSB +: GAIN_BITS];
   assign rx_gain = reg_a[RXG_LSB +: GAIN_BITS];

endmodule

// File: rtl/tdm_codec_port.sv
module tdm_codec_port
   import tdm_codec_port_pkg::*;
#(
   parameter int WORD_BITS  = 8,
   parameter int FRAME_BITS = 256,
   parameter int GAIN_BITS  = 3,
   parameter int TXG_LSB    = 0,
   parameter int RXG_LSB    = 3
) (
   input  logic                 bclk,
   input  logic                 rst_n,
   input  logic                 fsync_n,
   input  logic [1:0]           slot_addr,
   input  logic                 ctl_sin,
   input  logic                 pcm_in,
   input  logic [WORD_BITS-1:0] tx_pcm,
   output logic                 pcm_out,
   output logic                 pcm_oe,
   output logic [WORD_BITS-1:0] rx_pcm,
   output logic                 rx_strobe,
   output logic [WORD_BITS-1:0] ctl_a,
   output logic [WORD_BITS-1:0] ctl_b,
   output logic [GAIN_BITS-1:0] tx_gain,
   output logic [GAIN_BITS-1:0] rx_gain
);
   generate
      if (WORD_BITS < 2 || FRAME_BITS <= WORD_BITS) begin : g_bad_frame
         $error("frame must be longer than a word of at least 2 bits");
      end
      if (TXG_LSB + GAIN_BITS > WORD_BITS || RXG_LSB + GAIN_BITS > WORD_BITS) begin : g_bad_gain
         $error("gain fields must lie inside control register A");
      end
   endgenerate

   slot_mode_e           mode;
   logic                 slot, last, reload, clr_regs;
   logic                 ctl_valid, a_load, b_load;
   logic [WORD_BITS-1:0] ctl_word;

   tdm_frame_timer #(.WORD_BITS(WORD_BITS), .FRAME_BITS(FRAME_BITS)) u_timer (
      .clk(bclk), .rst_n(rst_n), .sync_n(fsync_n), .addr(slot_addr),
      .ctl_lvl(ctl_sin), .mode_o(mode), .slot_o(slot), .last_o(last),
      .reload_o(reload), .clr_o(clr_regs)
   );

   tdm_tx_serializer #(.W(WORD_BITS)) u_tx (
      .clk(bclk), .rst_n(rst_n), .load(reload), .shift(slot),
      .word(tx_pcm), .sout(pcm_out)
   );

   assign pcm_oe = slot;

   tdm_deser #(.W(WORD_BITS), .HOLD(1'b1)) u_rx (
      .clk(bclk), .rst_n(rst_n), .shift(slot), .commit(last),
      .sin(pcm_in), .word_o(rx_pcm), .valid_o(rx_strobe)
   );

   tdm_deser #(.W(WORD_BITS), .HOLD(1'b0)) u_ctl (
      .clk(bclk), .rst_n(rst_n), .shift(slot), .commit(last),
      .sin(ctl_sin), .word_o(ctl_word), .valid_o(ctl_valid)
   );

   assign a_load = ctl_valid && (mode == SLOT_A);
   assign b_load = ctl_valid && (mode == SLOT_B);

   tdm_ctl_bank #(
      .W(WORD_BITS), .GAIN_BITS(GAIN_BITS), .TXG_LSB(TXG_LSB), .RXG_LSB(RXG_LSB)
   ) u_bank (
      .clk(bclk), .rst_n(rst_n), .a_load(a_load), .b_load(b_load),
      .clr(clr_regs), .word(ctl_word), .reg_a(ctl_a), .reg_b(ctl_b),
      .tx_gain(tx_gain), .rx_gain(rx_gain)
   );

endmodule

// File: rtl/tdm_codec_port_chk.sv
module tdm_codec_port_chk #(
   parameter int WORD_BITS = 8
) (
   input logic                 bclk,
   input logic                 rst_n,
   input logic                 fsync_n,
   input logic [1:0]           slot_addr,
   input logic                 ctl_sin,
   input logic                 pcm_out,
   input logic                 pcm_oe,
   input logic                 rx_strobe,
   input logic [WORD_BITS-1:0] ctl_a,
   input logic [WORD_BITS-1:0] ctl_b,
   input logic                 a_load,
   input logic                 b_load,
   input logic                 clr_regs
);
   p_sync_opens_r2: assert property (@(posedge bclk) disable iff (!rst_n)
      (!fsync_n && (slot_addr == 2'b01 || slot_addr == 2'b10)) |=> pcm_oe);

   p_low_addr_closed_r5: assert property (@(posedge bclk) disable iff (!rst_n)
      (!fsync_n && (slot_addr == 2'b00 || slot_addr == 2'b11)) |=> !pcm_oe);

   p_quiet_when_off_r3: assert property (@(posedge bclk) disable iff (!rst_n)
      !pcm_oe |-> !pcm_out);

   p_strobe_single_r4: assert property (@(posedge bclk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

   p_strobe_after_slot_r4: assert property (@(posedge bclk) disable iff (!rst_n)
      rx_strobe |-> $past(pcm_oe));

   p_a_whole_word_r6: assert property (@(posedge bclk) disable iff (!rst_n)
      !$stable(ctl_a) |-> $past(a_load || clr_regs));

   p_b_whole_word_r6: assert property (@(posedge bclk) disable iff (!rst_n)
      !$stable(ctl_b) |-> $past(b_load || clr_regs));

   p_static_high_keeps_r8: assert property (@(posedge bclk) disable iff (!rst_n)
      (!fsync_n && slot_addr == 2'b00 && ctl_sin) |=> ($stable(ctl_a) && $stable(ctl_b)));

endmodule

bind tdm_codec_port tdm_codec_port_chk #(.WORD_BITS(WORD_BITS)) u_chk (
   .bclk(bclk), .rst_n(rst_n), .fsync_n(fsync_n), .slot_addr(slot_addr),
   .ctl_sin(ctl_sin), .pcm_out(pcm_out), .pcm_oe(pcm_oe), .rx_strobe(rx_strobe),
   .ctl_a(ctl_a), .ctl_b(ctl_b), .a_load(a_load), .b_load(b_load),
   .clr_regs(clr_regs)
);

// File: tb/tdm_codec_port_test.sv
module tdm_codec_port_test;
   localparam int CLK_PERIOD = 488;

   logic       bclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync_n = 1'b1;
   logic [1:0] slot_addr = 2'b00;
   logic       ctl_sin = 1'b0;
   logic       pcm_in = 1'b0;
   logic [7:0] tx_pcm = 8'h00;
   logic       pcm_out, pcm_oe, rx_strobe;
   logic [7:0] rx_pcm, ctl_a, ctl_b;
   logic [2:0] tx_gain, rx_gain;

   int checks = 0;
   int fails = 0;
   logic [7:0] exp_a = 8'h00, exp_b = 8'h00, exp_rx = 8'h00;
   logic [1:0] cur_addr = 2'b00;
   logic       cur_active = 1'b0;

   tdm_codec_port uut (
      .bclk(bclk), .rst_n(rst_n), .fsync_n(fsync_n), .slot_addr(slot_addr),
      .ctl_sin(ctl_sin), .pcm_in(pcm_in), .tx_pcm(tx_pcm), .pcm_out(pcm_out),
      .pcm_oe(pcm_oe), .rx_pcm(rx_pcm), .rx_strobe(rx_strobe), .ctl_a(ctl_a),
      .ctl_b(ctl_b), .tx_gain(tx_gain), .rx_gain(rx_gain)
   );

   always #(CLK_PERIOD / 2) bclk = ~bclk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic open_frame(input logic [1:0] a, input logic [7:0] tx, input logic lvl);
      @(negedge bclk);
      fsync_n = 1'b0;
      slot_addr = a;
      tx_pcm = tx;
      ctl_sin = lvl;
      pcm_in = 1'b0;
      @(posedge bclk);
      cur_addr = a;
      cur_active = (a == 2'b01) || (a == 2'b10);
      if (!cur_active && !lvl) begin
         exp_a = 8'h00;
         exp_b = 8'h00;
      end
   endtask

   task automatic run_slot(input logic [7:0] tx, input logic [7:0] rx,
                           input logic [7:0] ctl, input int nbits);
      for (int k = 0; k < nbits; k++) begin
         @(negedge bclk);
         fsync_n = 1'b1;
         check("R3 pcm_oe inside slot", pcm_oe, cur_active);
         check("R3 pcm_out bit", pcm_out, cur_active ? tx[7-k] : 1'b0);
         check("R6 ctl_a held mid-word", ctl_a, exp_a);
         check("R6 ctl_b held mid-word", ctl_b, exp_b);
         pcm_in = rx[7-k];
         ctl_sin = ctl[7-k];
         @(posedge bclk);
      end
      if (nbits == 8) begin
         @(negedge bclk);
         if (cur_active) exp_rx = rx;
         if (cur_addr == 2'b01) exp_a = ctl;
         if (cur_addr == 2'b10) exp_b = ctl;
         check("R4 rx_pcm word", rx_pcm, exp_rx);
         check("R4 rx_strobe pulse", rx_strobe, cur_active);
         check("R5 ctl_a after slot", ctl_a, exp_a);
         check("R5 ctl_b after slot", ctl_b, exp_b);
         check("R9 tx_gain field", tx_gain, exp_a[2:0]);
         check("R9 rx_gain field", rx_gain, exp_a[5:3]);
         check("R2 slot closed after 8 bits", pcm_oe, 1'b0);
         check("R3 pcm_out idle", pcm_out, 1'b0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] tx, rx, ctl;
      repeat (3) @(posedge bclk);
      @(negedge bclk);
      check("R1 pcm_oe in reset", pcm_oe, 1'b0);
      check("R1 pcm_out in reset", pcm_out, 1'b0);
      check("R1 rx_strobe in reset", rx_strobe, 1'b0);
      check("R1 rx_pcm in reset", rx_pcm, 8'h00);
      check("R1 ctl_a in reset", ctl_a, 8'h00);
      check("R1 ctl_b in reset", ctl_b, 8'h00);
      check("R1 gains in reset", {tx_gain, rx_gain}, 6'h00);
      rst_n = 1'b1;
      repeat (2) @(posedge bclk);

      // R5: every address code with several data patterns
      for (int a = 0; a < 4; a++) begin
         for (int p = 0; p < 4; p++) begin
            tx  = 8'hA5 ^ 8'(p * 37 + a);
            rx  = 8'h3C ^ 8'(p * 91 + a * 5);
            ctl = 8'h81 + 8'(p * 53 + a * 17);
            open_frame(a[1:0], tx, 1'b1);
            run_slot(tx, rx, ctl, 8);
         end
      end

      // R9: sweep every gain code
      for (int i = 0; i < 8; i++) begin
         ctl = {2'b10, 3'(7 - i), 3'(i)};
         open_frame(2'b01, 8'(i * 29), 1'b1);
         run_slot(8'(i * 29), 8'(255 - i), ctl, 8);
      end
      open_frame(2'b10, 8'hF0, 1'b1);
      run_slot(8'hF0, 8'h0F, 8'h6B, 8);

      // R8: static high keeps, static low clears
      tx = ctl_a;
      open_frame(2'b00, 8'h11, 1'b1);
      run_slot(8'h11, 8'h22, 8'h00, 8);
      check("R8 static high keeps ctl_a", ctl_a, tx);
      check("R8 static high keeps ctl_b", ctl_b, 8'h6B);
      open_frame(2'b11, 8'h11, 1'b0);
      run_slot(8'h11, 8'h22, 8'hFF, 8);
      check("R8 static low clears ctl_a", ctl_a, 8'h00);
      check("R8 static low clears ctl_b", ctl_b, 8'h00);

      // R7: sync mid-slot aborts the partial word
      open_frame(2'b01, 8'h3C, 1'b1);
      run_slot(8'h3C, 8'hFF, 8'hFF, 4);
      open_frame(2'b10, 8'hC3, 1'b1);
      run_slot(8'hC3, 8'h5A, 8'h96, 8);
      check("R7 aborted word leaves ctl_a", ctl_a, 8'h00);
      check("R7 restarted word lands in ctl_b", ctl_b, 8'h96);

      // R10: flywheel frame with no further sync
      open_frame(2'b01, 8'h4D, 1'b1);
      run_slot(8'h4D, 8'hB2, 8'h27, 8);
      tx_pcm = 8'h69;
      repeat (120) @(posedge bclk);
      @(negedge bclk);
      check("R10 quiet between slots", pcm_oe, 1'b0);
      repeat (128) @(posedge bclk);
      run_slot(8'h69, 8'hE1, 8'h1E, 8);
      check("R10 flywheel slot loads ctl_a", ctl_a, 8'h1E);
      check("R10 flywheel slot captures rx", rx_pcm, 8'hE1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule